// File: doc/BRIEF.md
# Pipeline Stall and Flush Controller

This block steers the pipeline registers of a five-stage in-order processor that has separate instruction and data caches. Each cycle it looks at the decode-stage source register indices, the load that currently sits in the execute stage, a multiply/divide busy flag, the two cache hit flags and an exception request. From these it decides, in the same cycle, which pipeline registers keep their contents (hold), which load a bubble (clear), and which back-end units have their write enables forced off (freeze).

It uses three distinct actions. A front-end problem holds the PC and the fetch/decode register and puts a bubble into the decode/execute register. This covers a load-use dependency, a busy multiply/divide unit and an instruction-cache miss. Because the fetch/decode register is held and not cleared, the instruction in the branch delay slot survives the stall. A data-cache miss holds the whole pipe and freezes the execute, memory and write-back units. An exception clears the three front pipeline registers. While reset is low, the block clears every pipeline register, so that the registers load bubbles on the synchronous reset edge.

Top module: `pipe_stall_ctl`

## Requirements
- R1: `raw_hazard` is 1 when `ex_mem_read` is 1, `ex_dst_idx` is nonzero and `ex_dst_idx` equals `id_rs_idx`.
- R2: `raw_hazard` is also 1 under the same load condition when `id_rt_is_src` is 1 and `ex_dst_idx` equals `id_rt_idx`. An rt match with `id_rt_is_src` at 0, or a destination index of 0, never raises it.
- R3: With reset high, both cache hits high and no exception, a raw hazard sets `pc_hold`, `ifid_hold` and `idex_clear`. All other hold, clear and freeze outputs are 0.
- R4: `md_busy` alone gives exactly the same outputs as R3.
- R5: `icache_hit` low alone gives exactly the same outputs as R3.
- R6: `dcache_hit` low with reset high sets all five hold outputs and all three freeze outputs, and sets every clear output to 0. This applies whatever the exception and front-end inputs are.
- R7: With `dcache_hit` high, `exc_req` sets `ifid_clear`, `idex_clear` and `exmem_clear`. It leaves every hold, freeze and `memwb_clear` at 0, even when front-end conditions are present.
- R8: `ifid_clear` is 1 only during reset or an exception taken without a data-cache miss. No front-end stall ever clears the delay-slot instruction.
- R9: While `rst_n` is 0, all four clear outputs and all three freeze outputs are 1, and all hold outputs are 0.
- R10: With reset high and no condition active, every hold, clear and freeze output is 0.
- R11: All outputs follow the current-cycle inputs with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only to sample the built-in checks |
| rst_n | input | 1 | Synchronous active-low reset of the pipeline |
| id_rs_idx | input | 5 | Decode-stage rs source index |
| id_rt_idx | input | 5 | Decode-stage rt index |
| id_rt_is_src | input | 1 | The decode instruction reads rt as a source |
| ex_mem_read | input | 1 | The execute-stage instruction is a load |
| ex_dst_idx | input | 5 | Destination index of the execute-stage instruction |
| md_busy | input | 1 | Multiply/divide unit busy interlock |
| icache_hit | input | 1 | Instruction-cache hit flag |
| dcache_hit | input | 1 | Data-cache hit flag |
| exc_req | input | 1 | Exception request |
| pc_hold | output | 1 | Keep the PC |
| ifid_hold | output | 1 | Keep the fetch/decode register |
| idex_hold | output | 1 | Keep the decode/execute register |
| exmem_hold | output | 1 | Keep the execute/memory register |
| memwb_hold | output | 1 | Keep the memory/write-back register |
| ifid_clear | output | 1 | Load a bubble into fetch/decode |
| idex_clear | output | 1 | Load a bubble into decode/execute |
| exmem_clear | output | 1 | Load a bubble into execute/memory |
| memwb_clear | output | 1 | Load a bubble into memory/write-back |
| ex_freeze | output | 1 | Block writes by the execute unit |
| mem_freeze | output | 1 | Block writes by the memory unit |
| wb_freeze | output | 1 | Block writes by the write-back unit |
| raw_hazard | output | 1 | Load-use hazard detected |

## Verification
The hardest case to reach is several conditions at once, where priority decides the outcome. Examples are a data-cache miss together with an exception and a load-use hazard, or an exception arriving during an instruction-cache miss. Random inputs alone seldom hit these because the hit flags are mostly high. The stimulus therefore biases register indices into a small range so that matches are frequent. It drives the hit flags low and the exception high at raised rates, and adds directed cases for each pair of conditions and for the zero-index and rt-not-a-source corners.

// File: rtl/pipe_ctl_pkg.sv
// Shared types for the pipeline stall/flush controller.
// Assumes five pipeline-register slots (PC plus four stage registers),
// four clearable stage registers and three freezable back-end units.
package pipe_ctl_pkg;
    localparam int N_HOLD   = 5;
    localparam int N_CLEAR  = 4;
    localparam int N_FREEZE = 3;

    // Bit positions inside the control vectors.
    localparam int H_PC = 0, H_IFID = 1, H_IDEX = 2, H_EXMEM = 3, H_MEMWB = 4;
    localparam int C_IFID = 0, C_IDEX = 1, C_EXMEM = 2, C_MEMWB = 3;
    localparam int F_EX = 0, F_MEM = 1, F_WB = 2;

    typedef struct packed {
        logic [N_HOLD-1:0]   hold;
        logic [N_CLEAR-1:0]  clear;
        logic [N_FREEZE-1:0] freeze;
    } ctl_vec_t;

    typedef enum logic [2:0] {
        MODE_RESET, MODE_DMISS, MODE_EXC, MODE_FRONT, MODE_RUN
    } ctl_mode_e;
endpackage

// File: rtl/pipe_hazard_det.sv
// Load-use hazard detector.
// Raises the hazard when the execute-stage load writes a nonzero register
// that the decode-stage instruction reads (rs always, rt when flagged).
// Assumes register 0 is hard-wired to zero and never creates a dependency.
module pipe_hazard_det #(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rs_idx,
    input  logic [IDX_W-1:0] rt_idx,
    input  logic             rt_is_src,
    input  logic             ld_valid,
    input  logic [IDX_W-1:0] ld_dst,
    output logic             hazard
);
    localparam logic [IDX_W-1:0] ZERO_IDX = '0;

    logic rs_match, rt_match;

    // Compare each source index against the pending load destination.
    always_comb begin
        rs_match = (rs_idx == ld_dst);
        rt_match = rt_is_src && (rt_idx == ld_dst);
        hazard   = ld_valid && (ld_dst != ZERO_IDX) && (rs_match || rt_match);
    end

    // R2: a zero destination never creates a dependency.
    p_zero_dst_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_dst == ZERO_IDX) |-> !hazard);
    // R1: only a load in execute can raise the hazard.
    p_needs_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |-> !hazard);
endmodule

// File: rtl/pipe_ctl_arbiter.sv
// Priority arbiter that turns pipeline conditions into hold/clear/freeze.
// Priority, highest first: reset, data-cache miss, exception, front-end
// stall (hazard, mul/div busy, instruction-cache miss), normal run.
// Assumes all inputs are valid in the current cycle; output is combinational.
module pipe_ctl_arbiter
    import pipe_ctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     front_stall,
    input  logic     dmiss,
    input  logic     exc_req,
    output ctl_vec_t ctl
);
    ctl_mode_e mode;

    // Pick the single winning condition for this cycle.
    always_comb begin
        if (!rst_n)           mode = MODE_RESET;
        else if (dmiss)       mode = MODE_DMISS;
        else if (exc_req)     mode = MODE_EXC;
        else if (front_stall) mode = MODE_FRONT;
        else                  mode = MODE_RUN;
    end

    // Expand the winning condition into the control vector.
    always_comb begin
        ctl = '0;
        unique case (mode)
            MODE_RESET: begin
                ctl.clear  = '1;
                ctl.freeze = '1;
            end
            MODE_DMISS: begin
                ctl.hold   = '1;
                ctl.freeze = '1;
            end
            MODE_EXC: begin
                ctl.clear[C_IFID]  = 1'b1;
                ctl.clear[C_IDEX]  = 1'b1;
                ctl.clear[C_EXMEM] = 1'b1;
            end
            MODE_FRONT: begin
                ctl.hold[H_PC]     = 1'b1;
                ctl.hold[H_IFID]   = 1'b1;
                ctl.clear[C_IDEX]  = 1'b1;
            end
            default: ctl = '0;
        endcase
    end

    // R6: a data-cache miss never clears any register.
    p_dmiss_no_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dmiss |-> (ctl.clear == '0));
    // R8: a front-end stall without exception keeps the delay-slot instruction.
    p_delay_slot_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (front_stall && !exc_req) |-> !ctl.clear[C_IFID]);
    // R7: an exception with the data cache hitting never holds anything.
    p_exc_no_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && !dmiss) |-> (ctl.hold == '0));
endmodule

// File: rtl/pipe_stall_ctl.sv
// Top of the pipeline stall/flush controller.
// Detects the load-use hazard, merges it with the other stall sources and
// drives per-register hold/clear and per-unit freeze outputs.
// Assumes synchronous active-low reset in the pipeline registers it steers.
module pipe_stall_ctl
    import pipe_ctl_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] id_rs_idx,
    input  logic [IDX_W-1:0] id_rt_idx,
    input  logic             id_rt_is_src,
    input  logic             ex_mem_read,
    input  logic [IDX_W-1:0] ex_dst_idx,
    input  logic             md_busy,
    input  logic             icache_hit,
    input  logic             dcache_hit,
    input  logic             exc_req,
    output logic             pc_hold,
    output logic             ifid_hold,
    output logic             idex_hold,
    output logic             exmem_hold,
    output logic             memwb_hold,
    output logic             ifid_clear,
    output logic             idex_clear,
    output logic             exmem_clear,
    output logic             memwb_clear,
    output logic             ex_freeze,
    output logic             mem_freeze,
    output logic             wb_freeze,
    output logic             raw_hazard
);
    logic     front_stall;
    ctl_vec_t ctl;

    pipe_hazard_det #(.IDX_W(IDX_W)) u_hazard (
        .clk       (clk),
        .rst_n     (rst_n),
        .rs_idx    (id_rs_idx),
        .rt_idx    (id_rt_idx),
        .rt_is_src (id_rt_is_src),
        .ld_valid  (ex_mem_read),
        .ld_dst    (ex_dst_idx),
        .hazard    (raw_hazard)
    );

    // Merge every front-end stall source into one request.
    always_comb front_stall = raw_hazard || md_busy || !icache_hit;

    pipe_ctl_arbiter u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .front_stall (front_stall),
        .dmiss       (!dcache_hit),
        .exc_req     (exc_req),
        .ctl         (ctl)
    );

    // Unpack the control vector onto named outputs.
    always_comb begin
        pc_hold     = ctl.hold[H_PC];
        ifid_hold   = ctl.hold[H_IFID];
        idex_hold   = ctl.hold[H_IDEX];
        exmem_hold  = ctl.hold[H_EXMEM];
        memwb_hold  = ctl.hold[H_MEMWB];
        ifid_clear  = ctl.clear[C_IFID];
        idex_clear  = ctl.clear[C_IDEX];
        exmem_clear = ctl.clear[C_EXMEM];
        memwb_clear = ctl.clear[C_MEMWB];
        ex_freeze   = ctl.freeze[F_EX];
        mem_freeze  = ctl.freeze[F_MEM];
        wb_freeze   = ctl.freeze[F_WB];
    end

    // R6: a held register is never cleared in the same cycle.
    p_hold_clear_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !((ifid_hold && ifid_clear) || (idex_hold && idex_clear)
          || (exmem_hold && exmem_clear) || (memwb_hold && memwb_clear)));
    // R3: a load-use hazard stalls the PC unless a higher condition wins.
    p_hazard_stalls_pc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_hazard && !exc_req) |-> pc_hold);
endmodule

// File: tb/pipe_stall_ctl_test.sv
module pipe_stall_ctl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] id_rs_idx = '0, id_rt_idx = '0, ex_dst_idx = '0;
    logic       id_rt_is_src = 1'b0, ex_mem_read = 1'b0, md_busy = 1'b0;
    logic       icache_hit = 1'b1, dcache_hit = 1'b1, exc_req = 1'b0;
    logic pc_hold, ifid_hold, idex_hold, exmem_hold, memwb_hold;
    logic ifid_clear, idex_clear, exmem_clear, memwb_clear;
    logic ex_freeze, mem_freeze, wb_freeze, raw_hazard;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    pipe_stall_ctl uut (.*);

    // Expected hazard from R1/R2.
    function automatic logic exp_haz(logic [4:0] rs, logic [4:0] rt, logic rtsrc,
                                     logic ld, logic [4:0] dst);
        return ld && (dst != 0) && ((dst == rs) || (rtsrc && dst == rt));
    endfunction

    // Expected vector {5 holds pc..memwb, 4 clears ifid..memwb, 3 freezes ex..wb}.
    function automatic logic [11:0] exp_vec(logic rst, logic haz, logic md,
                                            logic ih, logic dh, logic ex);
        if (!rst) return 12'b00000_1111_111;          // R9
        if (!dh)  return 12'b11111_0000_111;          // R6
        if (ex)   return 12'b00000_1110_000;          // R7
        if (haz || md || !ih) return 12'b11000_0100_000; // R3 R4 R5 R8
        return 12'b0;                                  // R10
    endfunction

    function automatic string tag_of(logic rst, logic haz, logic md,
                                     logic ih, logic dh, logic ex);
        if (!rst) return "R9";
        if (!dh)  return "R6";
        if (ex)   return "R7";
        if (haz)  return "R3";
        if (md)   return "R4";
        if (!ih)  return "R5";
        return "R10";
    endfunction

    task automatic apply(logic [4:0] rs, logic [4:0] rt, logic rtsrc, logic ld,
                         logic [4:0] dst, logic md, logic ih, logic dh, logic ex);
        logic [11:0] act, expv;
        logic eh;
        string t;
        @(negedge clk);
        id_rs_idx = rs; id_rt_idx = rt; id_rt_is_src = rtsrc; ex_mem_read = ld;
        ex_dst_idx = dst; md_busy = md; icache_hit = ih; dcache_hit = dh; exc_req = ex;
        #2;  // R11: outputs settle in the same cycle
        eh   = exp_haz(rs, rt, rtsrc, ld, dst);
        expv = exp_vec(rst_n, eh, md, ih, dh, ex);
        t    = tag_of(rst_n, eh, md, ih, dh, ex);
        act  = {pc_hold, ifid_hold, idex_hold, exmem_hold, memwb_hold,
                ifid_clear, idex_clear, exmem_clear, memwb_clear,
                ex_freeze, mem_freeze, wb_freeze};
        n_checks++;
        if (raw_hazard !== eh) begin
            n_fails++;
            $display("FAIL R1/R2 hazard: actual %b expected %b", raw_hazard, eh);
        end
        n_checks++;
        if (act !== expv) begin
            n_fails++;
            $display("FAIL %s R11 vector: actual %b expected %b", t, act, expv);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        // R9 reset state
        apply(5'd3, 5'd4, 1'b1, 1'b1, 5'd3, 1'b1, 1'b0, 1'b1, 1'b1);
        apply(5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b1, 1'b1, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        // R10 idle
        apply(5'd1, 5'd2, 1'b1, 1'b0, 5'd1, 1'b0, 1'b1, 1'b1, 1'b0);
        // R1 rs match, R3
        apply(5'd7, 5'd2, 1'b0, 1'b1, 5'd7, 1'b0, 1'b1, 1'b1, 1'b0);
        // R2 rt match as source / not a source / zero destination
        apply(5'd1, 5'd9, 1'b1, 1'b1, 5'd9, 1'b0, 1'b1, 1'b1, 1'b0);
        apply(5'd1, 5'd9, 1'b0, 1'b1, 5'd9, 1'b0, 1'b1, 1'b1, 1'b0);
        apply(5'd0, 5'd0, 1'b1, 1'b1, 5'd0, 1'b0, 1'b1, 1'b1, 1'b0);
        // R4, R5
        apply(5'd1, 5'd2, 1'b0, 1'b0, 5'd3, 1'b1, 1'b1, 1'b1, 1'b0);
        apply(5'd1, 5'd2, 1'b0, 1'b0, 5'd3, 1'b0, 1'b0, 1'b1, 1'b0);
        // R6 alone, with exception, with all front sources
        apply(5'd1, 5'd2, 1'b0, 1'b0, 5'd3, 1'b0, 1'b1, 1'b0, 1'b0);
        apply(5'd5, 5'd2, 1'b0, 1'b1, 5'd5, 1'b1, 1'b0, 1'b0, 1'b1);
        // R7 alone and over front stall, R8 delay slot kept
        apply(5'd1, 5'd2, 1'b0, 1'b0, 5'd3, 1'b0, 1'b1, 1'b1, 1'b1);
        apply(5'd5, 5'd2, 1'b0, 1'b1, 5'd5, 1'b1, 1'b0, 1'b1, 1'b1);
        // pairs of front sources
        apply(5'd5, 5'd2, 1'b0, 1'b1, 5'd5, 1'b1, 1'b0, 1'b1, 1'b0);
        // Constrained random: small index range, biased miss/exception rates.
        for (int i = 0; i < 2000; i++) begin
            apply(5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                  5'($urandom_range(0, 3)), 1'($urandom_range(0, 3) == 0),
                  1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 3) != 0),
                  1'($urandom_range(0, 4) == 0));
        end
        // R9 reset again mid-run
        @(negedge clk); rst_n = 1'b0;
        apply(5'd2, 5'd2, 1'b1, 1'b1, 5'd2, 1'b0, 1'b1, 1'b0, 1'b0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule